// File: doc/BRIEF.md
# Dual Reference Frequency Monitor

This block watches two reference clocks and reports, for each one, whether its frequency has drifted outside a parts-per-million window around its nominal value. Both references are asynchronous to the local system clock. Each one passes through a synchronizer and a rising-edge detector in the system domain. The rising edges are counted over a fixed gating interval that is measured in system clock cycles. For a two-second interval, that parameter is twice the system frequency.

All channels share one gating timer. When an interval closes, each channel compares its edge count with the nominal count. It sets its flag if the absolute difference is larger than the tolerance count. The tolerance count is derived from the nominal count and a ppm parameter, with the fraction rounded down. A channel that saw no edges at all is always flagged. The flag is registered and holds its value for the whole of the next interval. It is a slow, windowed quality indicator. It does not react the moment a reference misbehaves.

Top module: `dual_ref_freq_monitor`

## Requirements
- R1: Each reference input has its own counter and its own flag. The stimulus on one input never changes the flag of the other.
- R2: At the close of an interval, a channel's flag goes to 1 when its edge count N satisfies |N − NOMINAL_COUNT| > floor(NOMINAL_COUNT × TOL_PPM / 1e6).
- R3: At the close of an interval, a channel's flag goes to 0 when |N − NOMINAL_COUNT| is at or below that tolerance count. The exact boundary counts NOMINAL_COUNT ± tolerance read 0.
- R4: A channel that counted zero rising edges in an interval reads 1 after that interval closes.
- R5: Flags change only at interval closes, which come exactly every GATE_CYCLES system clock cycles. Between closes a flag holds, even if its reference changes or stops.
- R6: While reset is asserted, and after reset until the first interval closes (GATE_CYCLES cycles later), both flags read 0.
- R7: Each low-to-high transition of a reference, sampled through the synchronizer, adds exactly one to the count, however many system cycles the high level lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all counting and flags run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NUM_REFS | Reference clock inputs, asynchronous to clk |
| off_freq | output | NUM_REFS | Registered out-of-tolerance flag, one per reference |

## Verification
A wrong count or a wrong comparison shows up at the ports no sooner than the next interval close. Its effect is a flag value that is wrong for a full interval. The checks therefore hold a periodic stimulus with an exact edge count per interval, and read the flag only after one whole interval has passed under that stimulus. A misaligned gating timer, or a flag update outside the close, shows as a flag that moves at a cycle offset the bench tracks from reset. Double counting of long high levels would move a centred reference far out of tolerance within a single interval.

// File: rtl/drfm_pkg.sv
package drfm_pkg;

  localparam int unsigned PPM_SCALE = 1_000_000;

  // Tolerance count from a nominal count and a ppm figure (floor).
  function automatic logic [63:0] tol_from_ppm(input logic [63:0] nominal,
                                               input logic [63:0] ppm);
    logic [63:0] prod;
    prod = nominal * ppm;
    return prod / 64'(PPM_SCALE);
  endfunction

  // Magnitude of the signed difference between two unsigned counts.
  function automatic logic [63:0] abs_gap(input logic [63:0] a,
                                          input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Out-of-tolerance decision: no edges, or outside the window.
  function automatic logic beyond_window(input logic [63:0] count,
                                         input logic [63:0] nominal,
                                         input logic [63:0] tol);
    if (count == 64'd0) return 1'b1;
    return abs_gap(count, nominal) > tol;
  endfunction

endpackage

// File: rtl/drfm_edge_sync.sv
module drfm_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end
  end

  // chain_q[SYNC_STAGES-1] is the last synchronizer stage; the extra
  // stage holds its previous value for edge detection.
  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/drfm_gate_timer.sv
module drfm_gate_timer #(
  parameter int unsigned GATE_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int unsigned TMR_W    = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(GATE_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;

  assign win_end = (tmr_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (win_end) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

endmodule

// File: rtl/drfm_edge_counter.sv
module drfm_edge_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             win_end,
  output logic [CNT_W-1:0] win_total
);
  logic [CNT_W-1:0] cnt_q;

  // The total seen by the judge includes an edge that lands on the close.
  assign win_total = cnt_q + CNT_W'(rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (win_end) begin
      cnt_q <= '0;
    end else if (rise) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/drfm_tol_judge.sv
module drfm_tol_judge
  import drfm_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned NOMINAL_COUNT = 100,
  parameter int unsigned TOL_PPM       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [CNT_W-1:0] win_total,
  output logic             flag
);
  localparam logic [63:0] NOM64 = 64'(NOMINAL_COUNT);
  localparam logic [63:0] TOL64 = tol_from_ppm(64'(NOMINAL_COUNT), 64'(TOL_PPM));

  logic verdict;

  assign verdict = beyond_window(64'(win_total), NOM64, TOL64);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (win_end) begin
      flag <= verdict;
    end
  end

endmodule

// File: rtl/dual_ref_freq_monitor.sv
module dual_ref_freq_monitor #(
  parameter int unsigned NUM_REFS      = 2,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned GATE_CYCLES   = 100_000_000,
  parameter int unsigned NOMINAL_COUNT = 16_384_000,
  parameter int unsigned TOL_PPM       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_in,
  output logic [NUM_REFS-1:0] off_freq
);
  localparam int unsigned CNT_W = $clog2(GATE_CYCLES + 1);

  // Named internal events, observed by the bound checker.
  logic                           win_end;
  logic [NUM_REFS-1:0]            ref_rise;
  logic [NUM_REFS-1:0][CNT_W-1:0] win_total;

  drfm_gate_timer #(
    .GATE_CYCLES(GATE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_end (win_end)
  );

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_chan
    drfm_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ref_in[g]),
      .rise     (ref_rise[g])
    );

    drfm_edge_counter #(
      .CNT_W(CNT_W)
    ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (ref_rise[g]),
      .win_end   (win_end),
      .win_total (win_total[g])
    );

    drfm_tol_judge #(
      .CNT_W         (CNT_W),
      .NOMINAL_COUNT (NOMINAL_COUNT),
      .TOL_PPM       (TOL_PPM)
    ) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_end   (win_end),
      .win_total (win_total[g]),
      .flag      (off_freq[g])
    );
  end

endmodule

// File: rtl/drfm_checker.sv
module drfm_checker #(
  parameter int unsigned NUM_REFS      = 2,
  parameter int unsigned GATE_CYCLES   = 100_000_000,
  parameter int unsigned NOMINAL_COUNT = 16_384_000,
  parameter int unsigned TOL_PPM       = 12,
  parameter int unsigned CNT_W         = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           win_end,
  input logic [NUM_REFS-1:0]            ref_rise,
  input logic [NUM_REFS-1:0][CNT_W-1:0] win_total,
  input logic [NUM_REFS-1:0]            off_freq
);
  localparam int unsigned SW = $clog2(GATE_CYCLES + 1);
  localparam logic [SW-1:0] LAST = SW'(GATE_CYCLES - 1);
  localparam logic [63:0] TOL64 =
    drfm_pkg::tol_from_ppm(64'(NOMINAL_COUNT), 64'(TOL_PPM));
  localparam logic [63:0] HI64 = 64'(NOMINAL_COUNT) + TOL64;
  localparam logic [63:0] LO64 =
    (64'(NOMINAL_COUNT) > TOL64) ? 64'(NOMINAL_COUNT) - TOL64 : 64'd0;

  logic [SW-1:0] since_q;
  logic          seen_end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= '0;
      seen_end_q <= 1'b0;
    end else if (win_end) begin
      since_q    <= '0;
      seen_end_q <= 1'b1;
    end else begin
      since_q <= since_q + 1'b1;
    end
  end

  // R5: interval closes come exactly GATE_CYCLES apart, counted from reset.
  a_r5_close_period: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> (since_q == LAST))
    else $error("a_r5_close_period");

  // R5: flags hold between closes.
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(off_freq))
    else $error("a_r5_hold_between");

  // R6: no flag before the first close.
  a_r6_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_end_q |-> (off_freq == '0))
    else $error("a_r6_quiet_start");

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_chk
    // R7: one detected edge per transition, never two cycles in a row.
    a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ref_rise[g] |=> !ref_rise[g])
      else $error("a_r7_single_rise");

    // R4: empty interval flags the channel.
    a_r4_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && win_total[g] == '0) |=> off_freq[g])
      else $error("a_r4_zero_flags");

    // R2: count beyond the window flags the channel.
    a_r2_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && (64'(win_total[g]) > HI64 || 64'(win_total[g]) < LO64))
      |=> off_freq[g])
      else $error("a_r2_outside");

    // R3: nonzero count inside the window (bounds included) clears the flag.
    a_r3_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && win_total[g] != '0 && 64'(win_total[g]) <= HI64 &&
       64'(win_total[g]) >= LO64) |=> !off_freq[g])
      else $error("a_r3_inside");
  end

endmodule

bind dual_ref_freq_monitor drfm_checker #(
  .NUM_REFS      (NUM_REFS),
  .GATE_CYCLES   (GATE_CYCLES),
  .NOMINAL_COUNT (NOMINAL_COUNT),
  .TOL_PPM       (TOL_PPM),
  .CNT_W         (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_end   (win_end),
  .ref_rise  (ref_rise),
  .win_total (win_total),
  .off_freq  (off_freq)
);

// File: tb/dual_ref_freq_monitor_tb.sv
module dual_ref_freq_monitor_tb;
  localparam int unsigned G    = 2000;
  localparam int unsigned NOM  = 400;
  localparam int unsigned PPM  = 25000;   // tolerance count = 10

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_in = 2'b00;
  logic [1:0] off_freq;

  int unsigned n_set [2];
  bit          wide  [2];
  int unsigned cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dual_ref_freq_monitor #(
    .NUM_REFS(2), .SYNC_STAGES(2), .GATE_CYCLES(G),
    .NOMINAL_COUNT(NOM), .TOL_PPM(PPM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .off_freq(off_freq)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic bit exp_flag(input int unsigned n);
    int unsigned tol;
    int          d;
    tol = (NOM * PPM) / 1000000;
    d   = int'(n) - int'(NOM);
    if (d < 0) d = -d;
    return (n == 0) || (d > int'(tol));
  endfunction

  // Reference generators: a pattern with exactly n_set rising edges in any
  // G consecutive cycles (accumulator overflow), high for 1 or 3 cycles.
  initial begin
    int unsigned acc [2];
    int unsigned hold [2];
    acc[0] = 0; acc[1] = 777; hold[0] = 0; hold[1] = 0;
    n_set[0] = 0; n_set[1] = 0; wide[0] = 0; wide[1] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        if (n_set[k] != 0 && acc[k] + n_set[k] >= G) begin
          acc[k]  = acc[k] + n_set[k] - G;
          hold[k] = wide[k] ? 3 : 1;
        end else if (n_set[k] != 0) begin
          acc[k] = acc[k] + n_set[k];
        end
        ref_in[k] = (hold[k] > 0);
        if (hold[k] > 0) hold[k] = hold[k] - 1;
      end
    end
  end

  task automatic check(input string req, input bit got, input bit expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, expv, cyc);
    end
  endtask

  task automatic wait_phase(input int unsigned m);
    do @(negedge clk); while ((cyc % G) != m);
  endtask

  task automatic run_pair(input string req, input int unsigned a,
                          input int unsigned b, input bit wa, input bit wb);
    n_set[0] = a; n_set[1] = b; wide[0] = wa; wide[1] = wb;
    repeat (2 * G + 10) @(negedge clk);
    check({req, " ref0"}, off_freq[0], exp_flag(a));
    check({req, " ref1"}, off_freq[1], exp_flag(b));
  endtask

  initial begin
    process::self().srandom(32'd1357);
    repeat (5) @(negedge clk);
    // R6: flags low in reset and right after it.
    check("R6 in reset", off_freq[0] | off_freq[1], 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 after reset", off_freq[0] | off_freq[1], 1'b0);
    wait_phase(G - 5);
    check("R6 before first close", off_freq[0] | off_freq[1], 1'b0);
    wait_phase(5);
    // R4: no edges at all in the first interval.
    check("R4 ref0 empty", off_freq[0], 1'b1);
    check("R4 ref1 empty", off_freq[1], 1'b1);

    run_pair("R3 centred",          400, 400, 0, 0);
    run_pair("R3 boundary",         410, 390, 0, 0);
    run_pair("R2 just outside",     411, 389, 0, 0);
    run_pair("R1 R4 one silent",    400,   0, 0, 0);
    run_pair("R1 other silent",       0, 405, 0, 0);
    run_pair("R7 long highs",       400, 400, 1, 1);
    run_pair("R1 R2 split",         200, 408, 0, 1);

    // R5: flag holds until the close even after the reference stops.
    run_pair("R5 setup", 400, 400, 0, 0);
    wait_phase(3);
    n_set[0] = 0;
    wait_phase(G - 5);
    check("R5 held ref0", off_freq[0], 1'b0);
    check("R1 ref1 untouched", off_freq[1], 1'b0);
    wait_phase(5);
    check("R5 updated at close", off_freq[0], 1'b1);

    // Random counts around the window, R2/R3.
    for (int i = 0; i < 10; i++) begin
      int unsigned a, b;
      a = 380 + ($urandom % 41);
      b = 380 + ($urandom % 41);
      run_pair(exp_flag(a) ? "R2 random" : "R3 random", a, b,
               bit'($urandom % 2), bit'($urandom % 2));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule